// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block is a host-side engine that carries out one complete command exchange with a coprocessor. The two sides talk through two 32-bit mailbox registers and a message RAM of sixteen 32-bit words. A start pulse latches a sixteen-word command frame from an input array. The engine then waits for the coprocessor to report idle, copies the frame into the message RAM and raises the command mailbox. It polls for a nonzero response code, reads the sixteen reply words back and checks the reply checksum. Last, it clears the mailbox that the API version selects and reports a status word.

Every mailbox and RAM access goes through a simple register-bus master port. Each access is a single request that the target acknowledges. Frame word 0 is the header, word 1 the command and word 2 the argument count, with the arguments from word 3 onward. The reply uses the same layout. The position of the reply checksum follows from the reply's argument count.

Top module: `mbox_cmd_seq`

## Requirements
- R1: A bus request keeps its address, direction and write data stable until the target asserts `bus_ack_i`. Only one access is outstanding at a time. Addresses are byte addresses: the command mailbox is at 0x10, the response mailbox at 0x14, and message word i at 0x100 + 4*i.
- R2: After an accepted start, the block reads 0x14 until the value read is zero, using at most POLL_MAX reads. If all POLL_MAX reads are nonzero, it ends with status 0x10 and makes no write.
- R3: Once idle is seen, the block writes the latched command words 0 to 15 in ascending order to the message RAM. It then writes the value 1 to 0x10.
- R4: After that write, the block reads 0x14 until the value is nonzero, using at most POLL_MAX reads. The nonzero value is the response code. If all POLL_MAX reads are zero, the status is 0x10, but the block still reads the reply and releases the mailbox.
- R5: The block reads all sixteen message words back and presents them on `reply_o`, with word i at bits [32*i+31:32*i].
- R6: The checksum index is word 2 of the reply plus 3, clamped to 15. When the response code is 1, the 32-bit wrapping sum of the reply words below that index must equal the word at the index, or the status is 0x4.
- R7: A response code of 1 with a matching checksum gives status 0. Any other nonzero response code is reported with bit 31 cleared.
- R8: The last bus access writes 0. It goes to 0x14 when `api_ver_i` at start was below 3, and to 0x10 otherwise.
- R9: `busy_o` rises in the cycle after an accepted start. `done_o` is a one-cycle pulse in the cycle in which `busy_o` falls, and `status_o` is valid from that cycle on.
- R10: A start pulse while busy is ignored: the frame is not re-latched and no second exchange follows. No bus request is made while the block is not busy.
- R11: After reset, `busy_o`, `done_o`, `bus_req_o` and `status_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| api_ver_i | input | VER_W | API version, sampled at start |
| cmd_frame_i | input | WORDS*DATA_W | Command frame; word i at [32*i +: 32] |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle end-of-exchange pulse |
| status_o | output | DATA_W | Result code of the last exchange |
| reply_o | output | WORDS*DATA_W | Reply words read back |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Byte address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_ack_i | input | 1 | Access accepted; read data valid |
| bus_rdata_i | input | DATA_W | Read data |

## Verification
The bench sweeps the reply argument count across every unclamped value and a large value that must clamp. It runs each case once with a correct checksum and once with a corrupted one. A design that places the checksum off by one word, or that indexes past the frame, would report the wrong status.

Both poll limits are tested at exactly POLL_MAX-1 and POLL_MAX. A miscounted limit would time out early or poll once too often. An idle timeout must produce no writes at all, so a design that signals anyway is caught.

The bench also checks which mailbox is released for each API version and how coprocessor error codes come out with bit 31 stripped. It pulses start mid-exchange while changing the frame input, which exposes a design that re-latches the frame or starts a second exchange.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_IDLE,
        ST_WR_MSG,
        ST_SIGNAL,
        ST_WAIT_RESP,
        ST_RD_MSG,
        ST_RELEASE
    } seq_st_e;

    localparam logic [31:0] STS_OK      = 32'h0000_0000;
    localparam logic [31:0] STS_TIMEOUT = 32'h0000_0010;
    localparam logic [31:0] STS_CHKSUM  = 32'h0000_0004;
    localparam logic [31:0] RESP_GOOD   = 32'h0000_0001;

endpackage

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
    parameter int LIMIT = 1000,
    localparam int CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic tick_i,
    output logic last_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (tick_i) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // the poll now completing is the last one allowed
    assign last_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/mbox_word_buf.sv
module mbox_word_buf #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          load_i,
    input  logic [WORDS-1:0][DATA_W-1:0]  load_data_i,
    input  logic                          wr_i,
    input  logic [IDX_W-1:0]              wr_idx_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    output logic [WORDS-1:0][DATA_W-1:0]  q_o
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DATA_W-1:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (load_i)                               w_d = load_data_i[g];
            else if (wr_i && wr_idx_i == IDX_W'(g))   w_d = wr_data_i;
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) w_q <= '0;
            else         w_q <= w_d;
        end

        assign q_o[g] = w_q;
    end
endmodule

// File: rtl/mbox_chksum.sv
module mbox_chksum #(
    parameter int WORDS    = 16,
    parameter int DATA_W   = 32,
    parameter int ARGC_IDX = 2,
    localparam int IDX_W   = $clog2(WORDS)
) (
    input  logic [WORDS-1:0][DATA_W-1:0] words_i,
    output logic [IDX_W-1:0]             idx_o,
    output logic                         ok_o
);
    // smallest argument count whose index would reach or pass the last word
    localparam int CLAMP_ARGC = WORDS - ARGC_IDX - 2;

    logic [DATA_W-1:0] argc;
    logic [DATA_W-1:0] sum;

    assign argc = words_i[ARGC_IDX];

    always_comb begin
        if (argc >= DATA_W'(CLAMP_ARGC))
            idx_o = IDX_W'(WORDS - 1);
        else
            idx_o = argc[IDX_W-1:0] + IDX_W'(ARGC_IDX + 1);
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (i < int'(idx_o)) sum = sum + words_i[i];
        end
    end

    assign ok_o = (sum == words_i[idx_o]);
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
    import mbox_seq_pkg::*;
#(
    parameter int WORDS       = 16,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 12,
    parameter int VER_W       = 4,
    parameter int POLL_MAX    = 1000,
    parameter int REL_VER     = 3,
    parameter int ARGC_IDX    = 2,
    parameter int MSG_BASE    = 'h100,
    parameter int TO_CP_OFS   = 'h10,
    parameter int TO_HOST_OFS = 'h14,
    localparam int IDX_W      = $clog2(WORDS)
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          start_i,
    input  logic [VER_W-1:0]              api_ver_i,
    input  logic [WORDS-1:0][DATA_W-1:0]  cmd_frame_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic [DATA_W-1:0]             status_o,
    output logic [WORDS-1:0][DATA_W-1:0]  reply_o,
    output logic                          bus_req_o,
    output logic                          bus_we_o,
    output logic [ADDR_W-1:0]             bus_addr_o,
    output logic [DATA_W-1:0]             bus_wdata_o,
    input  logic                          bus_ack_i,
    input  logic [DATA_W-1:0]             bus_rdata_i
);
    localparam logic [ADDR_W-1:0] A_MSG     = ADDR_W'(MSG_BASE);
    localparam logic [ADDR_W-1:0] A_TO_CP   = ADDR_W'(TO_CP_OFS);
    localparam logic [ADDR_W-1:0] A_TO_HOST = ADDR_W'(TO_HOST_OFS);
    localparam logic [DATA_W-1:0] ERR_MASK  = ~(DATA_W'(1) << (DATA_W - 1));

    typedef struct packed {
        seq_st_e           st;
        logic [IDX_W-1:0]  idx;
        logic              tmo;
        logic              rel_host;
        logic [DATA_W-1:0] resp;
        logic              done;
        logic [DATA_W-1:0] status;
    } seq_t;

    seq_t s_d, s_q;

    logic                         accept;
    logic                         poll_clr, poll_tick, poll_last;
    logic                         rbuf_wr;
    logic [WORDS-1:0][DATA_W-1:0] cmd_q;
    logic [WORDS-1:0][DATA_W-1:0] rep_q;
    logic [IDX_W-1:0]             chk_idx;
    logic                         chk_ok;
    logic [ADDR_W-1:0]            msg_addr;
    logic [DATA_W-1:0]            final_sts;

    assign accept   = (s_q.st == ST_IDLE) && start_i;
    assign msg_addr = A_MSG + (ADDR_W'(s_q.idx) << 2);

    mbox_poll_timer #(.LIMIT(POLL_MAX)) i_poll (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (poll_clr),
        .tick_i (poll_tick),
        .last_o (poll_last)
    );

    mbox_word_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) i_cmd_buf (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (accept),
        .load_data_i (cmd_frame_i),
        .wr_i        (1'b0),
        .wr_idx_i    ('0),
        .wr_data_i   ('0),
        .q_o         (cmd_q)
    );

    mbox_word_buf #(.WORDS(WORDS), .DATA_W(DATA_W)) i_rep_buf (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (1'b0),
        .load_data_i ('0),
        .wr_i        (rbuf_wr),
        .wr_idx_i    (s_q.idx),
        .wr_data_i   (bus_rdata_i),
        .q_o         (rep_q)
    );

    mbox_chksum #(.WORDS(WORDS), .DATA_W(DATA_W), .ARGC_IDX(ARGC_IDX)) i_chk (
        .words_i (rep_q),
        .idx_o   (chk_idx),
        .ok_o    (chk_ok)
    );

    // result word formed when the release write completes
    always_comb begin
        if (s_q.tmo)
            final_sts = DATA_W'(STS_TIMEOUT);
        else if (s_q.resp == DATA_W'(RESP_GOOD))
            final_sts = chk_ok ? DATA_W'(STS_OK) : DATA_W'(STS_CHKSUM);
        else
            final_sts = s_q.resp & ERR_MASK;
    end

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        poll_clr    = 1'b0;
        poll_tick   = 1'b0;
        rbuf_wr     = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st       = ST_WAIT_IDLE;
                    s_d.idx      = '0;
                    s_d.tmo      = 1'b0;
                    s_d.resp     = '0;
                    s_d.rel_host = (api_ver_i < VER_W'(REL_VER));
                    poll_clr     = 1'b1;
                end
            end
            ST_WAIT_IDLE: begin
                bus_req_o  = 1'b1;
                bus_addr_o = A_TO_HOST;
                if (bus_ack_i) begin
                    if (bus_rdata_i == '0) begin
                        s_d.st   = ST_WR_MSG;
                        poll_clr = 1'b1;
                    end else if (poll_last) begin
                        s_d.st     = ST_IDLE;
                        s_d.done   = 1'b1;
                        s_d.status = DATA_W'(STS_TIMEOUT);
                        poll_clr   = 1'b1;
                    end else begin
                        poll_tick = 1'b1;
                    end
                end
            end
            ST_WR_MSG: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = msg_addr;
                bus_wdata_o = cmd_q[s_q.idx];
                if (bus_ack_i) begin
                    if (s_q.idx == IDX_W'(WORDS - 1)) begin
                        s_d.idx = '0;
                        s_d.st  = ST_SIGNAL;
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_SIGNAL: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = A_TO_CP;
                bus_wdata_o = DATA_W'(1);
                if (bus_ack_i) s_d.st = ST_WAIT_RESP;
            end
            ST_WAIT_RESP: begin
                bus_req_o  = 1'b1;
                bus_addr_o = A_TO_HOST;
                if (bus_ack_i) begin
                    if (bus_rdata_i != '0) begin
                        s_d.resp = bus_rdata_i;
                        s_d.st   = ST_RD_MSG;
                        poll_clr = 1'b1;
                    end else if (poll_last) begin
                        s_d.tmo  = 1'b1;
                        s_d.st   = ST_RD_MSG;
                        poll_clr = 1'b1;
                    end else begin
                        poll_tick = 1'b1;
                    end
                end
            end
            ST_RD_MSG: begin
                bus_req_o  = 1'b1;
                bus_addr_o = msg_addr;
                if (bus_ack_i) begin
                    rbuf_wr = 1'b1;
                    if (s_q.idx == IDX_W'(WORDS - 1)) begin
                        s_d.idx = '0;
                        s_d.st  = ST_RELEASE;
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_RELEASE: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = s_q.rel_host ? A_TO_HOST : A_TO_CP;
                bus_wdata_o = '0;
                if (bus_ack_i) begin
                    s_d.st     = ST_IDLE;
                    s_d.done   = 1'b1;
                    s_d.status = final_sts;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.st       <= ST_IDLE;
            s_q.idx      <= '0;
            s_q.tmo      <= 1'b0;
            s_q.rel_host <= 1'b0;
            s_q.resp     <= '0;
            s_q.done     <= 1'b0;
            s_q.status   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o   = (s_q.st != ST_IDLE);
    assign done_o   = s_q.done;
    assign status_o = s_q.status;
    assign reply_o  = rep_q;

    logic unused_chk_idx;
    assign unused_chk_idx = ^chk_idx;
endmodule

// File: rtl/mbox_seq_chk.sv
module mbox_seq_chk #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 12,
    parameter int TO_CP_OFS   = 'h10,
    parameter int TO_HOST_OFS = 'h14
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] status_o,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [DATA_W-1:0] bus_wdata_o,
    input logic              bus_ack_i
);
    a_r1_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o)
                                    && $stable(bus_we_o) && $stable(bus_wdata_o));

    a_r3_signal_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o && bus_we_o && bus_addr_o == ADDR_W'(TO_CP_OFS)
        |-> bus_wdata_o == DATA_W'(1) || bus_wdata_o == '0);

    a_r8_host_release_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o && bus_we_o && bus_addr_o == ADDR_W'(TO_HOST_OFS)
        |-> bus_wdata_o == '0);

    a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r9_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o && $past(busy_o));

    a_r7_status_bit31_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !status_o[DATA_W-1]);

    a_r10_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !bus_req_o);

    a_r10_start_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && start_i |=> busy_o || $past(done_o) || done_o);
endmodule

bind mbox_cmd_seq mbox_seq_chk #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .TO_CP_OFS   (TO_CP_OFS),
    .TO_HOST_OFS (TO_HOST_OFS)
) i_mbox_seq_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .status_o    (status_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i)
);

// File: tb/test_mbox_cmd_seq.sv
module test_mbox_cmd_seq;
    localparam int POLL = 6;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [3:0]          api = 4'd2;
    logic [15:0][31:0]   frame_in = '0;
    logic                busy, done;
    logic [31:0]         status;
    logic [15:0][31:0]   reply;
    logic                req, we;
    logic [11:0]         addr;
    logic [31:0]         wdata;
    logic                ack;
    logic [31:0]         rdata;

    always #4 clk = ~clk;

    mbox_cmd_seq #(.POLL_MAX(POLL)) i_mbox_cmd_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .api_ver_i(api),
        .cmd_frame_i(frame_in), .busy_o(busy), .done_o(done),
        .status_o(status), .reply_o(reply), .bus_req_o(req),
        .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
        .bus_ack_i(ack), .bus_rdata_i(rdata)
    );

    // coprocessor model configuration (written by the stimulus only)
    int              cfg_busy_n, cfg_delay;
    logic [31:0]     cfg_resp;
    logic [15:0][31:0] exp_frame, cfg_reply;

    // observation counters (written by the model only)
    int idle_reads, resp_reads, wr_cnt, mism, sig_cnt, rel_cp, rel_host, rd_cnt, phase;
    logic [31:0] ram [16];

    always @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            if (start && !busy) begin
                idle_reads = 0; resp_reads = 0; wr_cnt = 0; mism = 0;
                sig_cnt = 0; rel_cp = 0; rel_host = 0; rd_cnt = 0; phase = 0;
            end
            if (req && !ack) begin
                ack <= 1'b1;
                rdata <= '0;
                if (we) begin
                    if (addr >= 12'h100 && addr < 12'h140) begin
                        if (int'((addr - 12'h100) >> 2) != wr_cnt ||
                            wdata != exp_frame[(addr - 12'h100) >> 2]) mism++;
                        ram[(addr - 12'h100) >> 2] = wdata;
                        wr_cnt++;
                    end else if (addr == 12'h10 && wdata == 32'd1) begin
                        sig_cnt++;
                        phase = 1;
                        for (int k = 0; k < 16; k++) ram[k] = cfg_reply[k];
                    end else if (addr == 12'h10) rel_cp++;
                    else if (addr == 12'h14) rel_host++;
                end else begin
                    if (addr == 12'h14) begin
                        if (phase == 0) begin
                            rdata <= (idle_reads < cfg_busy_n) ? 32'h0BAD_0001 : 32'h0;
                            idle_reads++;
                        end else begin
                            rdata <= (resp_reads < cfg_delay) ? 32'h0 : cfg_resp;
                            resp_reads++;
                        end
                    end else if (addr >= 12'h100 && addr < 12'h140) begin
                        rdata <= ram[(addr - 12'h100) >> 2];
                        rd_cnt++;
                    end
                end
            end else begin
                ack <= 1'b0;
            end
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_case(input int ver, input int bsy, input int dly, input logic [31:0] resp,
                            input logic [31:0] argc, input bit corrupt, input bit poke);
        int idx;
        int cyc;
        logic [31:0] sum;
        logic [31:0] exp_sts;
        bit idle_to, resp_to;
        for (int k = 0; k < 16; k++) begin
            exp_frame[k] = 32'hC0DE_0000 + 32'(k * 17 + ver);
            cfg_reply[k] = 32'h1234_0000 ^ 32'(k * 977 + int'(argc[7:0]) * 3);
        end
        cfg_reply[0] = 32'd2;
        cfg_reply[2] = argc;
        idx = (argc >= 32'd12) ? 15 : int'(argc) + 3;
        sum = '0;
        for (int k = 0; k < 16; k++) if (k < idx) sum = sum + cfg_reply[k];
        cfg_reply[idx] = sum + (corrupt ? 32'h0000_0100 : 32'h0);
        cfg_busy_n = bsy; cfg_delay = dly; cfg_resp = resp;
        idle_to = (bsy >= POLL);
        resp_to = !idle_to && (dly >= POLL);
        if (idle_to || resp_to) exp_sts = 32'h10;
        else if (resp == 32'd1) exp_sts = corrupt ? 32'h4 : 32'h0;
        else exp_sts = resp & 32'h7FFF_FFFF;

        @(negedge clk);
        api = 4'(ver);
        frame_in = exp_frame;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R9 busy after start", 32'(busy), 32'd1);
        cyc = 0;
        while (!done && cyc < 20000) begin
            if (poke && cyc == 30) begin
                frame_in = ~exp_frame;
                api = 4'(ver ^ 1);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(cyc < 20000, "R9 watchdog done", 32'(cyc), 32'd0);
        chk(!busy, "R9 busy low with done", 32'(busy), 32'd0);
        chk(status == exp_sts, "R6/R7 status", status, exp_sts);
        chk(idle_reads == (idle_to ? POLL : bsy + 1), "R2 idle polls", 32'(idle_reads),
            32'(idle_to ? POLL : bsy + 1));
        if (idle_to) begin
            chk(wr_cnt == 0 && sig_cnt == 0 && rel_cp == 0 && rel_host == 0,
                "R2 no write after idle timeout", 32'(wr_cnt + sig_cnt), 32'd0);
        end else begin
            chk(wr_cnt == 16 && mism == 0, "R3 command words", 32'(wr_cnt * 256 + mism), 32'd4096);
            chk(sig_cnt == 1, "R3 signal write", 32'(sig_cnt), 32'd1);
            chk(resp_reads == (resp_to ? POLL : dly + 1), "R4 response polls", 32'(resp_reads),
                32'(resp_to ? POLL : dly + 1));
            chk(rd_cnt == 16 && reply == cfg_reply, "R5 reply words", 32'(rd_cnt), 32'd16);
            chk(rel_host == (ver < 3 ? 1 : 0) && rel_cp == (ver < 3 ? 0 : 1),
                "R8 release mailbox", 32'(rel_host * 16 + rel_cp), 32'(ver < 3 ? 16 : 1));
        end
        @(negedge clk);
        chk(!done, "R9 done single cycle", 32'(done), 32'd0);
        if (poke) begin
            repeat (40) @(negedge clk);
            chk(!busy && sig_cnt == 1, "R10 start while busy ignored", 32'(sig_cnt), 32'd1);
        end
    endtask

    initial begin
        exp_frame = '0; cfg_reply = '0; cfg_busy_n = 0; cfg_delay = 0; cfg_resp = 32'd1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !req && status == 0, "R11 reset state", status, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !req, "R10 bus quiet when idle", 32'(req), 32'd0);

        for (int a = 0; a < 14; a++) begin
            run_case((a % 2) ? 3 : 2, a % 3, a % 4, 32'd1, 32'(a), 1'b0, 1'b0);
            run_case((a % 2) ? 2 : 5, (a + 1) % 3, (a + 2) % 4, 32'd1, 32'(a), 1'b1, 1'b0);
        end
        // R6 clamp of a corrupt argument count
        run_case(2, 0, 0, 32'd1, 32'hFFFF_0000, 1'b0, 1'b0);
        run_case(3, 1, 1, 32'd1, 32'hFFFF_0000, 1'b1, 1'b0);
        // R7 coprocessor error codes
        for (int b = 0; b < 4; b++)
            run_case(2, 1, 2, 32'h8000_0000 | (32'd1 << b), 32'd2, 1'b0, 1'b0);
        run_case(3, 0, 1, 32'h0000_0042, 32'd1, 1'b1, 1'b0);
        // R4 response poll limit boundary
        run_case(2, 0, POLL - 1, 32'd1, 32'd3, 1'b0, 1'b0);
        run_case(3, 0, POLL, 32'd1, 32'd3, 1'b0, 1'b0);
        // R2 idle poll limit boundary
        run_case(2, POLL - 1, 0, 32'd1, 32'd4, 1'b0, 1'b0);
        run_case(2, POLL, 0, 32'd1, 32'd4, 1'b0, 1'b0);
        // R10 start pulse during an exchange
        run_case(2, 1, 2, 32'd1, 32'd5, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule